// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block forms the product of two 16-bit operands and uses it to update a 40-bit accumulator value. The operands can be treated as both signed, first signed and second unsigned, or both unsigned. The product can replace the accumulator, be added to it, or be subtracted from it. A fractional-mode input doubles the product before it is used. A saturation-mode input limits signed-by-signed results to the 32-bit signed range. The caller supplies the current accumulator value on `acc_in` and pulses `start` with all controls valid. One cycle later the new accumulator appears on `acc_out`, together with a one-cycle `done` pulse.

A control state machine with three states sequences each request. `ST_IDLE` is the state with no request. `ST_WRITE` is the cycle in which a legal result is presented and `done` is high. `ST_TRAP` is the cycle in which a rejected request is reported on `illegal`. From any state, the transitions are:
- to `ST_WRITE` on a legal `start`;
- to `ST_TRAP` on an illegal `start`;
- back to `ST_IDLE` when `start` is low.

Saturation requested without fractional mode is illegal. So are the reserved encodings of `sign_mode` and `op_sel`.

Top module: `frac_mac`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, `acc_out` is 0 and `done` and `illegal` are 0.
- R2: A legal `start` sampled at a clock edge makes `done` high for exactly the following cycle, with the new result on `acc_out` in that same cycle; `done` and `illegal` are never high together.
- R3: `sign_mode` selects operand interpretation: 0 = both signed, 1 = `opnd_a` signed and `opnd_b` unsigned, 2 = both unsigned.
- R4: `op_sel` selects the update: 0 = load the product, 1 = accumulator plus product, 2 = accumulator minus product. The accumulator input is read as a 40-bit two's-complement value, and unsaturated results wrap to 40 bits.
- R5: With `frac_en` = 1 the product is shifted left by one bit, kept to 40 bits and re-read as a signed 40-bit value before use.
- R6: For `sign_mode` 0 and `op_sel` 0 with `sat_en` = 1, a product above 0x7FFFFFFF is written as 0x7FFFFFFF; otherwise the 40-bit product is written.
- R7: For `sign_mode` 0 and `op_sel` 1 or 2 with `sat_en` = 1, a product above 0x7FFFFFFF is replaced by 0x7FFFFFFF before it is combined with the accumulator.
- R8: For `sign_mode` 0 and `op_sel` 1 or 2 with `sat_en` = 1, the final result is clamped to the range -0x80000000 to 0x7FFFFFFF (written as 40-bit two's complement).
- R9: For `sign_mode` 1 or 2, `sat_en` has no effect; results always wrap to 40 bits.
- R10: A `start` with `sat_en` = 1 and `frac_en` = 0, with `sign_mode` = 3, or with `op_sel` = 3 makes `illegal` high for the following cycle only. In that case `done` stays low and `acc_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one cycle per operation |
| opnd_a | input | 16 | First multiplier operand |
| opnd_b | input | 16 | Second multiplier operand |
| sign_mode | input | 2 | Operand signedness select (R3) |
| op_sel | input | 2 | Update select: load, add, subtract (R4) |
| frac_en | input | 1 | Fractional mode, doubles the product |
| sat_en | input | 1 | Saturation mode for signed-by-signed forms |
| acc_in | input | 40 | Current accumulator value |
| acc_out | output | 40 | Registered new accumulator value |
| done | output | 1 | One-cycle pulse marking a written result |
| illegal | output | 1 | One-cycle pulse marking a rejected request |

## Verification
The two clamps in the signed accumulate path can act in one operation. The product is limited first, and the sum is limited afterwards. This is provoked with operands 0x8000 × 0x8000 in fractional mode, whose doubled product is 0x80000000. Against an accumulator of -0x80000000, the correct result is -1 (0xFFFFFFFFFF). Skipping the product clamp would give 0 instead. The sweep also pairs extreme accumulators with extreme products, so that the final clamp triggers in both directions. Every case is judged against an arithmetic model built on 64-bit integers.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

    typedef enum logic [1:0] {
        SGN_SS = 2'd0,
        SGN_SU = 2'd1,
        SGN_UU = 2'd2,
        SGN_RSV = 2'd3
    } sign_mode_e;

    typedef enum logic [1:0] {
        UPD_LOAD = 2'd0,
        UPD_ADD  = 2'd1,
        UPD_SUB  = 2'd2,
        UPD_RSV  = 2'd3
    } upd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_TRAP  = 2'd2
    } mac_state_e;

endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int OPW  = 16,
    parameter int ACCW = 40
) (
    input  logic [OPW-1:0]         opnd_a,
    input  logic [OPW-1:0]         opnd_b,
    input  logic [1:0]             sign_mode,
    input  logic                   frac_en,
    output logic signed [ACCW-1:0] prod
);
    import frac_mac_pkg::*;

    localparam int PW   = 2 * OPW + 2;
    localparam int EXTW = ACCW - PW;

    logic                 a_sgn;
    logic                 b_sgn;
    logic signed [OPW:0]  a_ext;
    logic signed [OPW:0]  b_ext;
    logic signed [PW-1:0] raw;
    logic signed [ACCW-1:0] wide;

    always_comb begin
        a_sgn = (sign_mode != SGN_UU);
        b_sgn = (sign_mode == SGN_SS);
        a_ext = {a_sgn & opnd_a[OPW-1], opnd_a};
        b_ext = {b_sgn & opnd_b[OPW-1], opnd_b};
        raw   = a_ext * b_ext;
        wide  = {{EXTW{raw[PW-1]}}, raw};
        // doubling keeps 40 bits; bit 39 becomes the new sign
        prod  = frac_en ? {wide[ACCW-2:0], 1'b0} : wide;
    end

endmodule

// File: rtl/mac_combine.sv
module mac_combine #(
    parameter int ACCW = 40,
    parameter int SATW = 32
) (
    input  logic [ACCW-1:0]        acc_in,
    input  logic signed [ACCW-1:0] prod,
    input  logic [1:0]             op_sel,
    input  logic                   sat_on,
    output logic [ACCW-1:0]        result
);
    import frac_mac_pkg::*;

    localparam int ZW = ACCW - SATW + 2;
    localparam logic signed [ACCW:0] MAXV = {{ZW{1'b0}}, {(SATW-1){1'b1}}};
    localparam logic signed [ACCW:0] MINV = ~MAXV;

    logic signed [ACCW:0] acc_w;
    logic signed [ACCW:0] prod_w;
    logic signed [ACCW:0] prod_c;
    logic signed [ACCW:0] sum;

    always_comb begin
        acc_w  = {acc_in[ACCW-1], acc_in};
        prod_w = {prod[ACCW-1], prod};
        prod_c = (sat_on && (prod_w > MAXV)) ? MAXV : prod_w;
        unique case (op_sel)
            UPD_ADD: sum = acc_w + prod_c;
            UPD_SUB: sum = acc_w - prod_c;
            default: sum = prod_c;
        endcase
        if (sat_on && (sum > MAXV))
            result = MAXV[ACCW-1:0];
        else if (sat_on && (sum < MINV))
            result = MINV[ACCW-1:0];
        else
            result = sum[ACCW-1:0];
    end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] sign_mode,
    input  logic [1:0] op_sel,
    input  logic       frac_en,
    input  logic       sat_en,
    output logic       load_en,
    output logic       done,
    output logic       illegal
);
    import frac_mac_pkg::*;

    mac_state_e state_q;
    mac_state_e state_d;
    logic       legal;

    always_comb begin
        legal = !(sat_en && !frac_en) && (sign_mode != SGN_RSV) && (op_sel != UPD_RSV);
        if (start)
            state_d = legal ? ST_WRITE : ST_TRAP;
        else
            state_d = ST_IDLE;
        load_en = start && legal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        done    = 1'b0;
        illegal = 1'b0;
        unique case (state_q)
            ST_WRITE: done    = 1'b1;
            ST_TRAP:  illegal = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/frac_mac.sv
module frac_mac #(
    parameter int OPW  = 16,
    parameter int ACCW = 40,
    parameter int SATW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OPW-1:0]  opnd_a,
    input  logic [OPW-1:0]  opnd_b,
    input  logic [1:0]      sign_mode,
    input  logic [1:0]      op_sel,
    input  logic            frac_en,
    input  logic            sat_en,
    input  logic [ACCW-1:0] acc_in,
    output logic [ACCW-1:0] acc_out,
    output logic            done,
    output logic            illegal
);
    import frac_mac_pkg::*;

    logic signed [ACCW-1:0] prod;
    logic [ACCW-1:0]        result;
    logic                   load_en;
    logic                   sat_on;

    assign sat_on = sat_en && (sign_mode == SGN_SS);

    mac_product #(.OPW(OPW), .ACCW(ACCW)) u_prod (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .sign_mode (sign_mode),
        .frac_en   (frac_en),
        .prod      (prod)
    );

    mac_combine #(.ACCW(ACCW), .SATW(SATW)) u_comb (
        .acc_in (acc_in),
        .prod   (prod),
        .op_sel (op_sel),
        .sat_on (sat_on),
        .result (result)
    );

    mac_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sign_mode (sign_mode),
        .op_sel    (op_sel),
        .frac_en   (frac_en),
        .sat_en    (sat_en),
        .load_en   (load_en),
        .done      (done),
        .illegal   (illegal)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_out <= '0;
        else if (load_en)
            acc_out <= result;
    end

endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
    parameter int ACCW = 40,
    parameter int SATW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [1:0]      sign_mode,
    input logic [1:0]      op_sel,
    input logic            frac_en,
    input logic            sat_en,
    input logic [ACCW-1:0] acc_out,
    input logic            done,
    input logic            illegal
);
    localparam logic signed [ACCW-1:0] SMAX = {{(ACCW-SATW+1){1'b0}}, {(SATW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] SMIN = ~SMAX;

    logic req_ok;
    assign req_ok = !(sat_en && !frac_en) && (sign_mode != 2'd3) && (op_sel != 2'd3);

    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req_ok) |=> (done && !illegal));

    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));

    a_r10_trap_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !req_ok) |=> (illegal && !done));

    a_r10_acc_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(acc_out));

    a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(sat_en) && ($past(sign_mode) == 2'd0))
            |-> (($signed(acc_out) <= SMAX) && ($signed(acc_out) >= SMIN)));

endmodule

bind frac_mac frac_mac_chk #(.ACCW(ACCW), .SATW(SATW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sign_mode (sign_mode),
    .op_sel    (op_sel),
    .frac_en   (frac_en),
    .sat_en    (sat_en),
    .acc_out   (acc_out),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/sim_frac_mac.sv
`timescale 1ns/1ps
module sim_frac_mac;

    localparam longint MASK40 = 64'h00FF_FFFF_FFFF;
    localparam longint MAX32  = 64'h0000_0000_7FFF_FFFF;
    localparam longint MIN32  = -64'sh0000_0000_8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [1:0]  sign_mode = '0;
    logic [1:0]  op_sel = '0;
    logic        frac_en = 1'b0;
    logic        sat_en = 1'b0;
    logic [39:0] acc_in = '0;
    logic [39:0] acc_out;
    logic        done;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    logic [39:0] last_out;

    always #4 clk = ~clk;

    frac_mac u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .sign_mode(sign_mode), .op_sel(op_sel), .frac_en(frac_en), .sat_en(sat_en),
        .acc_in(acc_in), .acc_out(acc_out), .done(done), .illegal(illegal)
    );

    function automatic longint sx40(longint v);
        longint r;
        r = v & MASK40;
        if (r[39]) r = r | ~MASK40;
        return r;
    endfunction

    function automatic longint model(logic [15:0] a, logic [15:0] b, int sm, int op,
                                     bit fx, bit st, logic [39:0] acc);
        longint av, bv, p, s;
        bit ss;
        ss = (sm == 0);
        av = (sm != 2) ? longint'($signed(a)) : longint'(a);
        bv = (sm == 0) ? longint'($signed(b)) : longint'(b);
        p = av * bv;
        if (fx) p = sx40(p <<< 1);
        if (op == 0) begin
            s = (ss && st && p > MAX32) ? MAX32 : p;
        end else begin
            if (ss && st && p > MAX32) p = MAX32;
            s = (op == 1) ? sx40(longint'(acc)) + p : sx40(longint'(acc)) - p;
            if (ss && st) begin
                if (s > MAX32) s = MAX32;
                else if (s < MIN32) s = MIN32;
            end
        end
        return s & MASK40;
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(logic [15:0] a, logic [15:0] b, int sm, int op, bit fx, bit st,
                         logic [39:0] acc);
        @(negedge clk);
        opnd_a = a; opnd_b = b; sign_mode = 2'(sm); op_sel = 2'(op);
        frac_en = fx; sat_en = st; acc_in = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] vals [8];
        logic [39:0] accs [4];
        string tag;
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hC000, 16'h4000};
        accs = '{40'h00_0000_0000, 40'h00_7FFF_FFF0, 40'hFF_8000_0005, 40'h80_0000_0000};

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "acc_out in reset", longint'(acc_out), 0);
        check("R1", "done in reset", longint'(done), 0);
        check("R1", "illegal in reset", longint'(illegal), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "acc_out after reset", longint'(acc_out), 0);

        // R7: both clamps in one operation
        issue(16'h8000, 16'h8000, 0, 1, 1'b1, 1'b1, 40'hFF_8000_0000);
        check("R7", "product clamp before add", longint'(acc_out), 64'hFF_FFFF_FFFF);
        check("R2", "done with result", longint'(done), 1);
        @(negedge clk);
        check("R2", "done one cycle only", longint'(done), 0);

        // sweep
        for (int sm = 0; sm < 3; sm++)
            for (int op = 0; op < 3; op++)
                for (int md = 0; md < 3; md++)
                    for (int ia = 0; ia < 8; ia++)
                        for (int ib = 0; ib < 8; ib++)
                            for (int ic = 0; ic < 4; ic++) begin
                                bit fx;
                                bit st;
                                fx = (md != 0);
                                st = (md == 2);
                                if (st && sm == 0) tag = (op == 0) ? "R6" : "R8";
                                else if (st) tag = "R9";
                                else if (fx) tag = "R5";
                                else tag = (op == 0) ? "R3" : "R4";
                                issue(vals[ia], vals[ib], sm, op, fx, st, accs[ic]);
                                check(tag, $sformatf("sm%0d op%0d md%0d a=%h b=%h acc=%h",
                                      sm, op, md, vals[ia], vals[ib], accs[ic]),
                                      longint'(acc_out),
                                      model(vals[ia], vals[ib], sm, op, fx, st, accs[ic]));
                                if (done !== 1'b1) check("R2", "done pulse", longint'(done), 1);
                            end

        // R10: illegal requests leave acc_out unchanged
        last_out = acc_out;
        issue(16'h0003, 16'h0005, 0, 0, 1'b0, 1'b1, 40'h0);
        check("R10", "illegal for sat without frac", longint'(illegal), 1);
        check("R10", "no done on illegal", longint'(done), 0);
        check("R10", "acc held", longint'(acc_out), longint'(last_out));
        issue(16'h0003, 16'h0005, 3, 0, 1'b0, 1'b0, 40'h0);
        check("R10", "illegal for sign_mode 3", longint'(illegal), 1);
        check("R10", "acc held sign_mode 3", longint'(acc_out), longint'(last_out));
        issue(16'h0003, 16'h0005, 0, 3, 1'b0, 1'b0, 40'h0);
        check("R10", "illegal for op_sel 3", longint'(illegal), 1);
        @(negedge clk);
        check("R10", "illegal one cycle only", longint'(illegal), 0);
        check("R10", "acc still held", longint'(acc_out), longint'(last_out));

        // R9: sat has no effect on unsigned forms
        issue(16'hFFFF, 16'hFFFF, 2, 0, 1'b1, 1'b1, 40'h0);
        check("R9", "unsigned product not clamped", longint'(acc_out), 64'h1_FFFC_0002);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule